// File: doc/BRIEF.md
# Bus-Mapped GPIO Port with Access Checking

This block is an 8-pin general-purpose I/O peripheral that sits on a simple word-addressed system bus. Software sets the pin directions and the drive values, and it reads back the pin levels through three registers. In the direction register a set bit turns a pin into an input, so its driver is tri-stated. A cleared bit makes the pin an output that shows the stored output bit. The pins appear as three separate vectors: drive value, drive enable and sampled level.

Every bus access is checked in the cycle it is presented. A transfer size other than a full word, an offset that maps to no register, a write to the read-only input register and a read of the write-only output register all raise the error output, and none of them changes any state. A 3-bit bus mode input forces an asynchronous initialisation for three of its eight encodings. During that initialisation all registers return to their reset values and the read-data drivers are released.

Top module: `gpio_port`

## Requirements
- R1: The transfer size field encodes 00 as byte, 01 as halfword, 10 as word and 11 as reserved. Only 10 is accepted, and any other value asserts `err_o` for that access.
- R2: Only byte offsets 0x000 (direction), 0x004 (input) and 0x008 (output) are mapped. An access to any other offset, including unaligned ones, asserts `err_o`.
- R3: A write to the input register asserts `err_o`, and so does a read of the output register.
- R4: An access that asserts `err_o` changes no register. The pin outputs and later readback are the same as if the access had not happened.
- R5: The direction register is read/write in bits 7:0 and resets to 0xFF. Bits 31:8 of all read data are zero.
- R6: For each pin i, `pin_oe_o[i]` is the inverse of direction bit i. `pin_o[i]` carries output bit i while the pin is an output and is 0 otherwise. The stored output value survives changes of direction.
- R7: The input register samples `pin_i` through a two-stage synchroniser. A read returns the pin level that was present two clock edges earlier.
- R8: Bus mode 000, 010 or 011 asynchronously sets direction to 0xFF, clears the input and output registers, and deasserts `rdata_oe_o` and `err_o`, even in the middle of an access. All other mode values leave operation normal.
- R9: `rdata_oe_o` is high only during an error-free read of the direction or input register. Whenever it is low, `rdata_o` is zero.
- R10: A word write to offset 0x008 stores bits 7:0 as the output register. That value is visible only on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_mode_i | input | 3 | Bus mode; 000/010/011 force initialisation |
| sel_i | input | 1 | Access present this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| size_i | input | 2 | Transfer size code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Read-data driver enable |
| err_o | output | 1 | Bus error for the current access |
| pin_i | input | 8 | Pin levels |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Pin drive enables |

## Verification
The assertions check the following on every cycle:
- a non-word size always produces an error;
- a write to the input register always produces an error;
- an erroring access leaves the pins untouched;
- a released read bus carries zero;
- initialisation tri-states every pin and the read bus.

Only the bench scenarios can show the rest. They confirm that the value stored in the output register appears once a pin turns to output, and that the synchroniser's two-edge delay is restored after initialisation. They also confirm that each of the three initialisation modes works when applied in the middle of an access, and that the other mode values do not initialise.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    RSEL_DIR  = 2'd0,
    RSEL_IN   = 2'd1,
    RSEL_OUT  = 2'd2,
    RSEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned OFS_DIR = 'h000;
  localparam int unsigned OFS_IN  = 'h004;
  localparam int unsigned OFS_OUT = 'h008;

  function automatic logic mode_forces_init(input logic [2:0] mode);
    return (mode == 3'b000) || (mode == 3'b010) || (mode == 3'b011);
  endfunction
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              init_i,
  output logic              err_o,
  output logic              we_dir_o,
  output logic              we_out_o,
  output logic              re_o,
  output reg_sel_e          rsel_o
);
  logic size_ok, dir_ok, hit_ok;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFS_DIR): rsel_o = RSEL_DIR;
      ADDR_W'(OFS_IN):  rsel_o = RSEL_IN;
      ADDR_W'(OFS_OUT): rsel_o = RSEL_OUT;
      default:          rsel_o = RSEL_NONE;
    endcase
  end

  assign size_ok = (xfer_size_e'(size_i) == SZ_WORD);
  assign hit_ok  = (rsel_o != RSEL_NONE);

  // direction rules: input is read-only, output is write-only
  always_comb begin
    unique case (rsel_o)
      RSEL_IN:  dir_ok = !wr_i;
      RSEL_OUT: dir_ok = wr_i;
      default:  dir_ok = 1'b1;
    endcase
  end

  logic ok;
  assign ok       = sel_i && !init_i && size_ok && hit_ok && dir_ok;
  assign err_o    = sel_i && !init_i && !ok;
  assign we_dir_o = ok && wr_i && (rsel_o == RSEL_DIR);
  assign we_out_o = ok && wr_i && (rsel_o == RSEL_OUT);
  assign re_o     = ok && !wr_i;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned N      = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic         we_dir_i,
  input  logic         we_out_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] out_o,
  output logic [N-1:0] in_o
);
  logic [N-1:0] sync_q [SYNC_N];

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      dir_o <= '1;
      out_o <= '0;
    end else begin
      if (we_dir_i) dir_o <= wdata_i;
      if (we_out_i) out_o <= wdata_i;
    end
  end

  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)      sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pin_i;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign in_o = sync_q[SYNC_N-1];
endmodule

// File: rtl/gpio_pins.sv
module gpio_pins #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] out_i,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    // dir 1 = input (driver off)
    assign pin_oe_o[i] = ~dir_i[i];
    assign pin_o[i]    = dir_i[i] ? 1'b0 : out_i[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_mode_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              err_o,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o
);
  localparam int unsigned PAD_W = DATA_W - N;

  logic     init, arst;
  logic     we_dir, we_out, re;
  reg_sel_e rsel;
  logic [N-1:0] dir_q, out_q, in_q;

  assign init = mode_forces_init(bus_mode_i);
  assign arst = !rst_ni || init;

  gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i), .size_i(size_i),
    .init_i(init), .err_o(err_o), .we_dir_o(we_dir), .we_out_o(we_out),
    .re_o(re), .rsel_o(rsel)
  );

  gpio_regs #(.N(N), .SYNC_N(SYNC_N)) u_regs (
    .clk_i(clk_i), .arst_i(arst), .we_dir_i(we_dir), .we_out_i(we_out),
    .wdata_i(wdata_i[N-1:0]), .pin_i(pin_i),
    .dir_o(dir_q), .out_o(out_q), .in_o(in_q)
  );

  gpio_pins #(.N(N)) u_pins (
    .dir_i(dir_q), .out_i(out_q), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (re) begin
      unique case (rsel)
        RSEL_DIR: rdata_o = {{PAD_W{1'b0}}, dir_q};
        RSEL_IN:  rdata_o = {{PAD_W{1'b0}}, in_q};
        default:  rdata_o = '0;
      endcase
    end
  end
  assign rdata_oe_o = re;
endmodule

// File: rtl/gpio_port_sva.sv
module gpio_port_sva #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        bus_mode_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              err_o,
  input logic [N-1:0]      pin_o,
  input logic [N-1:0]      pin_oe_o
);
  logic init_m;
  assign init_m = (bus_mode_i == 3'b000) || (bus_mode_i == 3'b010) || (bus_mode_i == 3'b011);

  assert_bad_size_R1: assert property (@(posedge clk_i) disable iff (!rst_ni || init_m)
    (sel_i && size_i != 2'b10) |-> err_o);

  assert_wr_input_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || init_m)
    (sel_i && wr_i && addr_i == ADDR_W'('h004)) |-> err_o);

  assert_err_no_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || init_m)
    err_o |=> ($stable(pin_o) && $stable(pin_oe_o)));

  assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (rdata_o[DATA_W-1:N] == '0));

  assert_undriven_pin_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);

  assert_init_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_m |-> (pin_oe_o == '0 && !rdata_oe_o && !err_o));

  assert_idle_bus_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));
endmodule

bind gpio_port gpio_port_sva #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_mode_i(bus_mode_i), .sel_i(sel_i),
  .wr_i(wr_i), .addr_i(addr_i), .size_i(size_i), .rdata_o(rdata_o),
  .rdata_oe_o(rdata_oe_o), .err_o(err_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  bus_mode_i = 3'b001;
  logic        sel_i = 1'b0, wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  size_i = 2'b10;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rdata_oe_o, err_o;
  logic [7:0]  pin_i = 8'hA5;
  logic [7:0]  pin_o, pin_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_port dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        err;
    logic        rv;
    logic [31:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{1'b0, 12'h000, 2'b10, 32'h0,         1'b0, 1'b1, 32'h0000_00FF, 4'd5},  // R5 reset value
    '{1'b1, 12'h000, 2'b10, 32'hFFFF_FF0F, 1'b0, 1'b0, 32'h0,         4'd5},  // R5 write
    '{1'b0, 12'h000, 2'b10, 32'h0,         1'b0, 1'b1, 32'h0000_000F, 4'd5},  // R5 readback, upper zero
    '{1'b1, 12'h008, 2'b10, 32'h0000_003C, 1'b0, 1'b0, 32'h0,         4'd10}, // R10
    '{1'b0, 12'h008, 2'b10, 32'h0,         1'b1, 1'b0, 32'h0,         4'd3},  // R3 read output
    '{1'b1, 12'h004, 2'b10, 32'h0000_0055, 1'b1, 1'b0, 32'h0,         4'd3},  // R3 write input
    '{1'b0, 12'h004, 2'b10, 32'h0,         1'b0, 1'b1, 32'h0000_00A5, 4'd7},  // R7
    '{1'b0, 12'h00C, 2'b10, 32'h0,         1'b1, 1'b0, 32'h0,         4'd2},  // R2
    '{1'b1, 12'h002, 2'b10, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'd2},  // R2 unaligned
    '{1'b1, 12'h000, 2'b00, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'd1},  // R1 byte
    '{1'b1, 12'h000, 2'b01, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'd1},  // R1 half
    '{1'b1, 12'h000, 2'b11, 32'h0000_0000, 1'b1, 1'b0, 32'h0,         4'd1},  // R1 reserved
    '{1'b0, 12'h000, 2'b10, 32'h0,         1'b0, 1'b1, 32'h0000_000F, 4'd4},  // R4 unchanged
    '{1'b0, 12'h000, 2'b00, 32'h0,         1'b1, 1'b0, 32'h0,         4'd9}   // R9 no drive on error
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = wr; addr_i = a; size_i = s; wdata_i = d;
  endtask

  task automatic idle();
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
    drive(1'b1, a, 2'b10, d);
    @(posedge clk_i);
    idle();
  endtask

  task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    drive(1'b0, a, 2'b10, 32'h0);
    #2;
    chk(req, {31'b0, rdata_oe_o}, 32'd1);
    chk(req, rdata_o, exp);
    @(posedge clk_i);
    idle();
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R5 reset oe", {24'b0, pin_oe_o}, 32'h0);
    chk("R9 reset rdata_oe", {31'b0, rdata_oe_o}, 32'h0);
    chk("R9 reset rdata", rdata_o, 32'h0);
    repeat (3) @(posedge clk_i);

    for (int i = 0; i < 14; i++) begin
      drive(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      #2;
      chk($sformatf("R%0d vec%0d err", VECS[i].req, i), {31'b0, err_o}, {31'b0, VECS[i].err});
      chk($sformatf("R%0d vec%0d oe", VECS[i].req, i), {31'b0, rdata_oe_o}, {31'b0, VECS[i].rv});
      chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rdata_o, VECS[i].rdata);
      @(posedge clk_i);
    end
    idle();
    #2;
    chk("R9 idle err", {31'b0, err_o}, 32'h0);
    chk("R9 idle rdata", rdata_o, 32'h0);
    // dir 0x0F, out 0x3C
    chk("R6 pin_oe", {24'b0, pin_oe_o}, 32'hF0);
    chk("R6 pin_o", {24'b0, pin_o}, 32'h30);

    // R4: erroring write to output keeps pins
    drive(1'b1, 12'h008, 2'b01, 32'hFF);
    @(posedge clk_i); idle(); #2;
    chk("R4 pins after bad write", {24'b0, pin_o}, 32'h30);

    // R6: stored value surfaces when direction flips
    write_reg(12'h000, 32'h0);
    #2;
    chk("R6 all out oe", {24'b0, pin_oe_o}, 32'hFF);
    chk("R6 all out value", {24'b0, pin_o}, 32'h3C);
    write_reg(12'h000, 32'hFF);
    #2;
    chk("R6 all in value", {24'b0, pin_o}, 32'h00);
    write_reg(12'h000, 32'h0);

    // R7: pin change seen after two edges
    @(negedge clk_i); pin_i = 8'h5A;
    read_chk("R7 synced", 12'h004, 32'hA5);
    read_chk("R7 synced new", 12'h004, 32'h5A);

    // R8: non-init modes leave state alone
    foreach (VECS[k]) begin end
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m == 2 || m == 3) continue;
      @(negedge clk_i); bus_mode_i = 3'(m); #2;
      chk($sformatf("R8 mode %0d no init", m), {24'b0, pin_oe_o}, 32'hFF);
    end
    @(negedge clk_i); bus_mode_i = 3'b001;

    // R8: each init mode applied mid-access
    for (int j = 0; j < 3; j++) begin
      logic [2:0] md;
      md = (j == 0) ? 3'b000 : (j == 1) ? 3'b010 : 3'b011;
      write_reg(12'h000, 32'h0);
      write_reg(12'h008, 32'h3C);
      repeat (2) @(posedge clk_i);
      drive(1'b0, 12'h000, 2'b10, 32'h0);
      #2; bus_mode_i = md; #1;
      chk($sformatf("R8 mode %0d pin_oe", md), {24'b0, pin_oe_o}, 32'h0);
      chk($sformatf("R8 mode %0d pin_o", md), {24'b0, pin_o}, 32'h0);
      chk($sformatf("R8 mode %0d rdata_oe", md), {31'b0, rdata_oe_o}, 32'h0);
      chk($sformatf("R8 mode %0d err", md), {31'b0, err_o}, 32'h0);
      @(posedge clk_i);
      idle();
      bus_mode_i = 3'b001;
      drive(1'b0, 12'h004, 2'b10, 32'h0);
      #2;
      chk($sformatf("R8 mode %0d input cleared", md), rdata_o, 32'h0);
      @(posedge clk_i); idle();
      read_chk($sformatf("R8 mode %0d dir FF", md), 12'h000, 32'hFF);
      read_chk($sformatf("R7 mode %0d resync", md), 12'h004, 32'h5A);
      write_reg(12'h000, 32'h0);
      #2;
      chk($sformatf("R8 mode %0d out cleared", md), {24'b0, pin_o}, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule